// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit gathers the interrupt events of an I2C controller into one place. Ten event sources are sticky: a one-cycle pulse sets a status bit, and the bit stays set until software clears it. Two sources follow levels. The receive-full source compares the receive FIFO fill level against a threshold, and the transmit-empty source compares the transmit FIFO fill level against a threshold. A mask register selects which status bits may raise the single interrupt line. That line is held low whenever the controller is disabled.

Software clears interrupts by reading. Each sticky source has its own clear address, and a read there clears that bit alone. A combined clear address clears every sticky bit in one read. A transmit-abort cause vector records which abort reasons have occurred. Any nonzero cause also raises the abort status bit. The vector is zeroed by the read that clears the abort bit. The logic that produces the events, and the FIFOs themselves, sit outside this unit.

Top module: `irq_status_unit`

## Requirements
- R1: Status bit positions are: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A pulse on `evt_pulse[k]` sets raw bit k (read at address 2) for every k except 2 and 4. Pulses on bits 2 and 4 have no effect.
- R2: The mask register (address 0, reset 0) reads back as written. The masked status register (address 1) equals raw status AND mask.
- R3: A read of address 16+k returns the prior raw bit k in bit 0. For a sticky source k, that read clears bit k and leaves every other bit unchanged.
- R4: A read of address 6 returns in bit 0 whether any sticky bit was set, and clears all sticky bits.
- R5: Cause bits on `abort_cause` accumulate by OR into the cause vector (address 5), and any nonzero cause sets raw bit 6. The read that clears bit 6 (address 22 or address 6) also zeroes the vector.
- R6: Raw bit 2 is 1 exactly while `rx_level` is greater than the receive threshold (address 3).
- R7: Raw bit 4 is 1 exactly while `tx_level` is less than or equal to the transmit threshold (address 4).
- R8: An event or cause that arrives in the same cycle as a clear read of its bit wins: the bit stays set, and the new cause bits are kept.
- R9: `irq` is the OR of the masked status bits while `ctrl_en` is 1, and it is 0 while `ctrl_en` is 0.
- R10: After reset, every sticky bit, the mask, both thresholds and the cause vector are 0.
- R11: Writes never clear status. A clear read at a level-source address (18 or 20) leaves that bit following its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enabled; gates the interrupt line |
| evt_pulse | input | 12 | One-cycle event pulses, one per status bit |
| abort_cause | input | 13 | Transmit-abort reason pulses |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear addresses act on it) |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 13 | Read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt output |

## Verification
The hardest case to reach from the ports is the collision in which an event and the clear read of its own bit land on the same clock edge. The stimulus therefore raises the event strobe and the clear read strobe together on one falling edge, for a plain source, for the abort cause vector, and for the combined clear. It then reads the status back. The threshold comparators are swept over every level and threshold pair. The mask is swept over all 4096 values against a fixed status pattern, with the enable toggled along the way.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NSRC    = 12;
  localparam int CAUSE_W = 13;
  localparam int ADDR_W  = 5;
  localparam int RD_W    = (NSRC > CAUSE_W) ? NSRC : CAUSE_W;

  localparam int IDX_RX_FULL  = 2;
  localparam int IDX_TX_EMPTY = 4;
  localparam int IDX_TX_ABRT  = 6;

  localparam logic [NSRC-1:0] LEVEL_SRC = NSRC'((1 << IDX_RX_FULL) | (1 << IDX_TX_EMPTY));
  localparam logic [NSRC-1:0] EDGE_SRC  = ~LEVEL_SRC;

  localparam int A_MASK     = 0;
  localparam int A_MSTAT    = 1;
  localparam int A_RAW      = 2;
  localparam int A_RXTHR    = 3;
  localparam int A_TXTHR    = 4;
  localparam int A_CAUSE    = 5;
  localparam int A_CLRALL   = 6;
  localparam int A_CLR_BASE = 16;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_status_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set_vec,
  input  logic [NSRC-1:0]  clr_vec,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic [LVL_W-1:0] tx_thr,
  output logic [NSRC-1:0]  raw_stat
);
  logic unused_lvl_bits;
  assign unused_lvl_bits = ^{set_vec & LEVEL_SRC, clr_vec & LEVEL_SRC};

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (k == IDX_RX_FULL) begin : g_rxfull
      assign raw_stat[k] = (rx_level > rx_thr);
    end else if (k == IDX_TX_EMPTY) begin : g_txempty
      assign raw_stat[k] = (tx_level <= tx_thr);
    end else begin : g_sticky
      logic bit_q, bit_d, bit_en;

      always_comb begin
        bit_en = set_vec[k] | clr_vec[k];
        bit_d  = set_vec[k];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_en) bit_q <= bit_d;
      end

      assign raw_stat[k] = bit_q;

      assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[k] |=> bit_q);
      assert_clear_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[k] && !set_vec[k]) |=> !bit_q);
      assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q && !clr_vec[k]) |=> bit_q);
    end
  end
endmodule

// File: rtl/abort_cause_hold.sv
module abort_cause_hold
  import irq_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic               cause_clr,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               abort_evt
);
  logic [CAUSE_W-1:0] cause_d;
  logic               cause_en;

  always_comb begin
    cause_en  = cause_clr | (|cause_in);
    cause_d   = (cause_clr ? '0 : cause_q) | cause_in;
    abort_evt = |cause_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assert_cause_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_clr && cause_in == '0) |=> cause_q == '0);
  assert_cause_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_clr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  assert_cause_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cause_clr |=> cause_q == $past(cause_in));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_status_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NSRC-1:0]    reg_wdata,
  input  logic [NSRC-1:0]    raw_stat,
  input  logic [NSRC-1:0]    mstat,
  input  logic [CAUSE_W-1:0] cause,
  output logic [NSRC-1:0]    mask_q,
  output logic [LVL_W-1:0]   rx_thr_q,
  output logic [LVL_W-1:0]   tx_thr_q,
  output logic [NSRC-1:0]    clr_vec,
  output logic               cause_clr,
  output logic [RD_W-1:0]    reg_rdata
);
  logic mask_we, rxthr_we, txthr_we, clrall_hit;

  always_comb begin
    mask_we    = reg_wr && (reg_addr == ADDR_W'(A_MASK));
    rxthr_we   = reg_wr && (reg_addr == ADDR_W'(A_RXTHR));
    txthr_we   = reg_wr && (reg_addr == ADDR_W'(A_TXTHR));
    clrall_hit = reg_rd && (reg_addr == ADDR_W'(A_CLRALL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_thr_q <= '0;
    else if (rxthr_we) rx_thr_q <= reg_wdata[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_thr_q <= '0;
    else if (txthr_we) tx_thr_q <= reg_wdata[LVL_W-1:0];
  end

  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      clr_vec[k] = EDGE_SRC[k] &&
                   (clrall_hit || (reg_rd && (reg_addr == ADDR_W'(A_CLR_BASE + k))));
    end
    cause_clr = clr_vec[IDX_TX_ABRT];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_MASK):   reg_rdata = RD_W'(mask_q);
      ADDR_W'(A_MSTAT):  reg_rdata = RD_W'(mstat);
      ADDR_W'(A_RAW):    reg_rdata = RD_W'(raw_stat);
      ADDR_W'(A_RXTHR):  reg_rdata = RD_W'(rx_thr_q);
      ADDR_W'(A_TXTHR):  reg_rdata = RD_W'(tx_thr_q);
      ADDR_W'(A_CAUSE):  reg_rdata = RD_W'(cause);
      ADDR_W'(A_CLRALL): reg_rdata = RD_W'(|(raw_stat & EDGE_SRC));
      default: begin
        for (int k = 0; k < NSRC; k++) begin
          if (reg_addr == ADDR_W'(A_CLR_BASE + k)) reg_rdata = RD_W'(raw_stat[k]);
        end
      end
    endcase
  end

  assert_mask_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(reg_wdata));
  assert_rxthr_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxthr_we |=> rx_thr_q == $past(reg_wdata[LVL_W-1:0]));
  assert_no_clr_on_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> clr_vec == '0);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_en,
  input  logic [NSRC-1:0]    evt_pulse,
  input  logic [CAUSE_W-1:0] abort_cause,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NSRC-1:0]    reg_wdata,
  output logic [RD_W-1:0]    reg_rdata,
  output logic               irq
);
  logic [NSRC-1:0]    set_vec, clr_vec, raw_stat, mask_q, mstat;
  logic [LVL_W-1:0]   rx_thr_q, tx_thr_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               cause_clr, abort_evt;

  always_comb begin
    set_vec              = evt_pulse;
    set_vec[IDX_TX_ABRT] = evt_pulse[IDX_TX_ABRT] | abort_evt;
    mstat                = raw_stat & mask_q;
    irq                  = ctrl_en & (|mstat);
  end

  irq_cfg_regs #(.LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .raw_stat(raw_stat), .mstat(mstat), .cause(cause_q),
    .mask_q(mask_q), .rx_thr_q(rx_thr_q), .tx_thr_q(tx_thr_q),
    .clr_vec(clr_vec), .cause_clr(cause_clr), .reg_rdata(reg_rdata)
  );

  abort_cause_hold u_cause (
    .clk(clk), .rst_n(rst_n),
    .cause_in(abort_cause), .cause_clr(cause_clr),
    .cause_q(cause_q), .abort_evt(abort_evt)
  );

  irq_src_bank #(.LVL_W(LVL_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_thr(rx_thr_q), .tx_thr(tx_thr_q),
    .raw_stat(raw_stat)
  );

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !irq);
  assert_abort_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_cause != '0) |=> raw_stat[IDX_TX_ABRT]);
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_en;
  logic [11:0] evt_pulse;
  logic [12:0] abort_cause;
  logic [3:0]  rx_level, tx_level;
  logic        reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [11:0] reg_wdata;
  logic [12:0] reg_rdata;
  logic        irq;

  always #5 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .evt_pulse(evt_pulse),
    .abort_cause(abort_cause), .rx_level(rx_level), .tx_level(tx_level),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  logic [11:0] lat;
  logic [12:0] cz;
  int rxt, txt;

  localparam logic [11:0] EDGE = 12'hFEB;

  function automatic logic [11:0] exp_raw();
    return lat | ((int'(rx_level) > rxt) ? 12'h004 : 12'h000)
               | ((int'(tx_level) <= txt) ? 12'h010 : 12'h000);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 5'(a); reg_rd = 1'b1;
    #1 d = 32'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clr(input int k, output logic [31:0] d);
    rd(16 + k, d);
    if (EDGE[k]) lat[k] = 1'b0;
    if (k == 6) cz = '0;
  endtask

  task automatic wr(input int a, input logic [11:0] v);
    @(negedge clk);
    reg_addr = 5'(a); reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 3) rxt = int'(v[3:0]);
    if (a == 4) txt = int'(v[3:0]);
  endtask

  task automatic pulse(input logic [11:0] e, input logic [12:0] c);
    @(negedge clk);
    evt_pulse = e; abort_cause = c;
    @(negedge clk);
    evt_pulse = '0; abort_cause = '0;
    lat = lat | (e & EDGE) | ((c != 0) ? 12'h040 : 12'h000);
    cz  = cz | c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [11:0] r;
    rst_n = 1'b0; ctrl_en = 1'b1; evt_pulse = '0; abort_cause = '0;
    rx_level = '0; tx_level = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    lat = '0; cz = '0; rxt = 0; txt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state (tx level 0 <= threshold 0 gives bit 4)
    rd(2, d); chk("R10 raw", d, 32'h010);
    rd(0, d); chk("R10 mask", d, 0);
    rd(3, d); chk("R10 rxthr", d, 0);
    rd(4, d); chk("R10 txthr", d, 0);
    rd(5, d); chk("R10 cause", d, 0);
    #1 chk("R10 irq", 32'(irq), 0);

    tx_level = 4'd15;
    // R1 / R3 each source alone
    for (int k = 0; k < 12; k++) begin
      if (k == 6) pulse('0, 13'h0001);
      else        pulse(12'(1 << k), '0);
      rd(2, d); chk($sformatf("R1 set bit %0d", k), d, 32'(exp_raw()));
      clr(k, d); chk($sformatf("R3 clr ret %0d", k), d, EDGE[k] ? 1 : 0);
      rd(2, d); chk($sformatf("R3 after clr %0d", k), d, 32'(exp_raw()));
    end

    // R3 clear one at a time from all set
    pulse(12'hFFF, 13'h0001);
    for (int k = 0; k < 12; k++) begin
      if (!EDGE[k]) continue;
      clr(k, d);
      rd(2, d); chk($sformatf("R3 only bit %0d", k), d, 32'(exp_raw()));
    end
    rd(5, d); chk("R5 cause zero via bit clr", d, 0);

    // R4 / R5 clear-all
    pulse(12'hFAB, 13'h1001);
    pulse('0, 13'h0008);
    rd(5, d); chk("R5 cause accum", d, 32'h1009);
    rd(2, d); chk("R5 abort bit", d, 32'(exp_raw()));
    rd(6, d); chk("R4 clrall ret", d, 1);
    lat = '0; cz = '0;
    rd(2, d); chk("R4 all clear", d, 32'(exp_raw()));
    rd(5, d); chk("R5 cause cleared by clrall", d, 0);
    rd(6, d); chk("R4 clrall ret empty", d, 0);

    // R8 same-cycle event and clear
    @(negedge clk); evt_pulse = 12'h200; reg_rd = 1'b1; reg_addr = 5'd25;
    @(negedge clk); evt_pulse = '0; reg_rd = 1'b0; lat[9] = 1'b1;
    rd(2, d); chk("R8 event beats own clear", d, 32'(exp_raw()));
    @(negedge clk); evt_pulse = 12'h080; reg_rd = 1'b1; reg_addr = 5'd6;
    @(negedge clk); evt_pulse = '0; reg_rd = 1'b0; lat = 12'h080;
    rd(2, d); chk("R8 event beats clrall", d, 32'(exp_raw()));
    pulse('0, 13'h0002);
    @(negedge clk); abort_cause = 13'h0100; reg_rd = 1'b1; reg_addr = 5'd22;
    @(negedge clk); abort_cause = '0; reg_rd = 1'b0; cz = 13'h0100;
    rd(5, d); chk("R8 new cause kept", d, 32'h0100);
    rd(2, d); chk("R8 abort bit kept", d, 32'(exp_raw()));

    // R11 writes never clear; level clear has no effect
    rx_level = 4'd5;
    wr(6, 12'hFFF); wr(22, 12'hFFF); wr(2, 12'h000); wr(25, 12'hFFF);
    rd(2, d); chk("R11 writes no clear", d, 32'(exp_raw()));
    rd(18, d); chk("R11 level clr ret", d, 1);
    rd(2, d); chk("R11 level bit follows", d, 32'(exp_raw()));
    rd(6, d); lat = '0; cz = '0;

    // R6 / R7 exhaustive threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr(3, 12'(t)); wr(4, 12'(15 - t));
      rd(3, d); chk("R6 rxthr readback", d, 32'(t));
      for (int l = 0; l < 16; l++) begin
        @(negedge clk); rx_level = 4'(l); tx_level = 4'(15 - l);
        rd(2, d);
        chk($sformatf("R6 rx l=%0d t=%0d", l, t), {31'b0, d[2]}, (l > t) ? 1 : 0);
        chk($sformatf("R7 tx l=%0d t=%0d", 15 - l, 15 - t), {31'b0, d[4]},
            ((15 - l) <= (15 - t)) ? 1 : 0);
      end
    end

    // R2 / R9 mask sweep
    wr(3, 12'd0); wr(4, 12'd0);
    rx_level = 4'd3; tx_level = 4'd9;
    pulse(12'hFAB, 13'h0400);
    r = exp_raw();
    rd(2, d); chk("R2 pattern", d, 32'(r));
    for (int m = 0; m < 4096; m++) begin
      ctrl_en = ((m % 97) != 5);
      wr(0, 12'(m));
      rd(1, d); chk($sformatf("R2 masked m=%h", m), d, 32'(r & 12'(m)));
      chk($sformatf("R9 irq m=%h en=%0d", m, ctrl_en), 32'(irq),
          (ctrl_en && ((r & 12'(m)) != 0)) ? 1 : 0);
      if ((m % 512) == 7) begin
        rd(0, d); chk("R2 mask readback", d, 32'(m));
      end
    end
    ctrl_en = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule